// File: doc/BRIEF.md
# Simultaneous-Access Row-Buffered Memory

This block is a word memory split across a power-of-two number of banks. Each bank holds one word of every row. A single row fetch drives the same row index into all banks at once, so one access returns a whole row of consecutive words. That row is captured into a set of per-bank holding registers. A multiplexer steered by the low-order word offset then hands the words out one per cycle. Two holding sets are kept, so the fetch of the following row runs while the current row is still being streamed out.

A client requests a read by giving a start word address and a word count on a valid/ready handshake. The words appear on an output stream with a valid flag and a last flag. Any start address is accepted: the first row is entered at the requested offset. Whole rows are written through a separate port, which is refused for as long as a read is running.

Top module: `row_buffered_mem`

## Requirements
- R1: After reset, `reqReady` and `wrReady` are high and `outValid` and `outLast` are low.
- R2: An accepted row write stores bits `[b*WORD_W +: WORD_W]` of `wrData` as the word at address `wrRow*BANKS + b`, for every bank `b`, in one access.
- R3: A read of `reqLen` words from `reqAddr` delivers the words at `reqAddr`, `reqAddr+1`, ... in order, one per `outValid` cycle, exactly `reqLen` of them. Addresses wrap modulo `ROWS*BANKS`.
- R4: When a read starts at an address that is not a multiple of `BANKS`, the first word comes from bank `reqAddr mod BANKS` of the first row. The stream then continues at bank 0 of the next row.
- R5: The first word of a read is valid in the cycle after the `FETCH_LAT`-th rising edge that follows the accepting edge.
- R6: `outLast` is high together with the final word of a read and at no other time. `reqReady` is high again in the cycle after that word.
- R7: A request of length zero is accepted, produces no output word, and leaves `reqReady` high.
- R8: While a read runs, `reqReady` and `wrReady` are low. A row write offered during that time is not taken and leaves memory contents unchanged.
- R9: With `FETCH_LAT <= BANKS` and a start address that is a multiple of `BANKS`, every word of the read is delivered on consecutive cycles, because the next row is fetched while the current one streams.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqAddr | input | $clog2(ROWS)+$clog2(BANKS) | Start word address of a read |
| reqLen | input | LEN_W | Number of words to read |
| reqValid | input | 1 | Read request offered |
| reqReady | output | 1 | Read request can be taken (idle) |
| outData | output | WORD_W | Streamed word |
| outValid | output | 1 | `outData` holds a word this cycle |
| outLast | output | 1 | Final word of the current read |
| wrValid | input | 1 | Row write offered |
| wrRow | input | $clog2(ROWS) | Row index to write |
| wrData | input | BANKS*WORD_W | One word per bank, bank 0 in the low bits |
| wrReady | output | 1 | Row write can be taken (idle) |

## Verification
The bench builds the block with 4 banks, 8 rows, 8-bit words, a 3-cycle fetch and a 6-bit length. With these values a read can span the whole 32-word space and wrap past the top address. Because the fetch is shorter than a row, gap-free streaming across row handovers can be observed. Unaligned starts, a one-word read at the last bank, a zero-length request and a write attempted mid-read are each driven, and every word is compared against a bench-held copy of memory.

// File: rtl/row_buffered_pkg.sv
package row_buffered_pkg;
  typedef struct packed {
    logic memWrite;  // store the offered row into all banks
    logic loadBuf;   // capture the fetched row into a holding set
    logic loadSel;   // holding set being filled
    logic rdSel;     // holding set being streamed out
  } ctlStrobe_t;
endpackage

// File: rtl/row_buffered_dp.sv
module row_buffered_dp
  import row_buffered_pkg::*;
#(
  parameter int BANKS  = 8,
  parameter int ROWS   = 16,
  parameter int WORD_W = 8
) (
  input  logic                            clk,
  input  ctlStrobe_t                      strobes,
  input  logic [$clog2(ROWS)-1:0]         wrRow,
  input  logic [BANKS*WORD_W-1:0]         wrData,
  input  logic [$clog2(ROWS)-1:0]         fetchRow,
  input  logic [$clog2(BANKS)-1:0]        rdOff,
  output logic [WORD_W-1:0]               outData
);
  logic [WORD_W-1:0] bankWord [BANKS];

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [WORD_W-1:0] cells [ROWS];
    logic [WORD_W-1:0] hold  [2];

    always_ff @(posedge clk) begin
      if (strobes.memWrite) cells[wrRow] <= wrData[b*WORD_W +: WORD_W];
      if (strobes.loadBuf)  hold[strobes.loadSel] <= cells[fetchRow];
    end

    assign bankWord[b] = hold[strobes.rdSel];
  end

  assign outData = bankWord[rdOff];
endmodule

// File: rtl/row_buffered_ctrl.sv
module row_buffered_ctrl
  import row_buffered_pkg::*;
#(
  parameter int BANKS     = 8,
  parameter int ROWS      = 16,
  parameter int FETCH_LAT = 8,
  parameter int LEN_W     = 8
) (
  input  logic                                    clk,
  input  logic                                    rstN,
  input  logic [$clog2(ROWS)+$clog2(BANKS)-1:0]   reqAddr,
  input  logic [LEN_W-1:0]                        reqLen,
  input  logic                                    reqValid,
  output logic                                    reqReady,
  input  logic                                    wrValid,
  output logic                                    wrReady,
  output logic                                    outValid,
  output logic                                    outLast,
  output ctlStrobe_t                              strobes,
  output logic [$clog2(ROWS)-1:0]                 fetchRow,
  output logic [$clog2(BANKS)-1:0]                rdOff
);
  localparam int OFF_W  = $clog2(BANKS);
  localparam int ROW_W  = $clog2(ROWS);
  localparam int CNT_W  = $clog2(FETCH_LAT + 1);
  localparam int RLEN_W = LEN_W + OFF_W + 1;

  logic              busy, fetching, wrSel, rdSel;
  logic [1:0]        full, fullNext;
  logic [CNT_W-1:0]  cntQ;
  logic [ROW_W-1:0]  rowQ;
  logic [OFF_W-1:0]  offQ;
  logic [LEN_W-1:0]  wordsLeft;
  logic [RLEN_W-1:0] rowsToFetch, rowsNeed;

  logic acceptRun, outFire, lastWord, releaseBuf, doneNow, nextSel, slotFree, startNext;

  always_comb begin
    acceptRun  = reqValid && !busy && (reqLen != '0);
    outFire    = busy && full[rdSel];
    lastWord   = outFire && (wordsLeft == LEN_W'(1));
    releaseBuf = outFire && ((offQ == OFF_W'(BANKS - 1)) || (wordsLeft == LEN_W'(1)));
    doneNow    = fetching && (cntQ == CNT_W'(1));
    nextSel    = doneNow ? ~wrSel : wrSel;
    slotFree   = !full[nextSel] || (releaseBuf && (rdSel == nextSel));
    startNext  = busy && (rowsToFetch != '0) && (!fetching || doneNow) && slotFree;
    rowsNeed   = (RLEN_W'(reqAddr[OFF_W-1:0]) + RLEN_W'(reqLen) + RLEN_W'(BANKS - 1)) >> OFF_W;
    fullNext   = full;
    if (doneNow)    fullNext[wrSel] = 1'b1;
    if (releaseBuf) fullNext[rdSel] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy        <= 1'b0;
      fetching    <= 1'b0;
      wrSel       <= 1'b0;
      rdSel       <= 1'b0;
      full        <= '0;
      cntQ        <= '0;
      rowQ        <= '0;
      offQ        <= '0;
      wordsLeft   <= '0;
      rowsToFetch <= '0;
    end else if (acceptRun) begin
      busy        <= 1'b1;
      fetching    <= 1'b1;
      cntQ        <= CNT_W'(FETCH_LAT);
      rowQ        <= reqAddr[OFF_W +: ROW_W];
      offQ        <= reqAddr[OFF_W-1:0];
      wordsLeft   <= reqLen;
      rowsToFetch <= rowsNeed - RLEN_W'(1);
      wrSel       <= 1'b0;
      rdSel       <= 1'b0;
      full        <= '0;
    end else if (busy) begin
      full <= fullNext;
      if (outFire) begin
        offQ      <= offQ + OFF_W'(1);
        wordsLeft <= wordsLeft - LEN_W'(1);
      end
      if (releaseBuf) rdSel <= ~rdSel;
      if (doneNow)    wrSel <= ~wrSel;
      if (startNext) begin
        fetching    <= 1'b1;
        cntQ        <= CNT_W'(FETCH_LAT);
        rowQ        <= rowQ + ROW_W'(1);
        rowsToFetch <= rowsToFetch - RLEN_W'(1);
      end else if (doneNow) begin
        fetching <= 1'b0;
      end else if (fetching) begin
        cntQ <= cntQ - CNT_W'(1);
      end
      if (lastWord) busy <= 1'b0;
    end
  end

  assign reqReady = !busy;
  assign wrReady  = !busy;
  assign outValid = outFire;
  assign outLast  = lastWord;
  assign fetchRow = rowQ;
  assign rdOff    = offQ;

  always_comb begin
    strobes.memWrite = wrValid && !busy;
    strobes.loadBuf  = doneNow;
    strobes.loadSel  = wrSel;
    strobes.rdSel    = rdSel;
  end
endmodule

// File: rtl/row_buffered_mem.sv
module row_buffered_mem
  import row_buffered_pkg::*;
#(
  parameter int BANKS     = 8,
  parameter int ROWS      = 16,
  parameter int WORD_W    = 8,
  parameter int FETCH_LAT = 8,
  parameter int LEN_W     = 8
) (
  input  logic                                    clk,
  input  logic                                    rstN,
  input  logic [$clog2(ROWS)+$clog2(BANKS)-1:0]   reqAddr,
  input  logic [LEN_W-1:0]                        reqLen,
  input  logic                                    reqValid,
  output logic                                    reqReady,
  output logic [WORD_W-1:0]                       outData,
  output logic                                    outValid,
  output logic                                    outLast,
  input  logic                                    wrValid,
  input  logic [$clog2(ROWS)-1:0]                 wrRow,
  input  logic [BANKS*WORD_W-1:0]                 wrData,
  output logic                                    wrReady
);
  ctlStrobe_t                   strobes;
  logic [$clog2(ROWS)-1:0]      fetchRow;
  logic [$clog2(BANKS)-1:0]     rdOff;

  row_buffered_ctrl #(
    .BANKS(BANKS), .ROWS(ROWS), .FETCH_LAT(FETCH_LAT), .LEN_W(LEN_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .reqAddr(reqAddr), .reqLen(reqLen), .reqValid(reqValid), .reqReady(reqReady),
    .wrValid(wrValid), .wrReady(wrReady),
    .outValid(outValid), .outLast(outLast),
    .strobes(strobes), .fetchRow(fetchRow), .rdOff(rdOff)
  );

  row_buffered_dp #(
    .BANKS(BANKS), .ROWS(ROWS), .WORD_W(WORD_W)
  ) u_dp (
    .clk(clk), .strobes(strobes),
    .wrRow(wrRow), .wrData(wrData),
    .fetchRow(fetchRow), .rdOff(rdOff),
    .outData(outData)
  );
endmodule

// File: rtl/row_buffered_chk.sv
module row_buffered_chk #(
  parameter int LEN_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic [LEN_W-1:0] reqLen,
  input logic             reqReady,
  input logic             wrReady,
  input logic             outValid,
  input logic             outLast
);
  // R8
  write_blocked_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !wrReady);

  // R7
  zero_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqLen == '0) |=> (reqReady && !outValid));

  // R6
  last_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> outValid);

  // R6
  last_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    outLast |=> reqReady);

  // R5
  no_early_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqLen != '0) |=> (!outValid && !reqReady));
endmodule

bind row_buffered_mem row_buffered_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqLen(reqLen),
  .reqReady(reqReady), .wrReady(wrReady), .outValid(outValid), .outLast(outLast)
);

// File: tb/sim_row_buffered_mem.sv
module sim_row_buffered_mem;
  localparam int BANKS = 4, ROWS = 8, WORD_W = 8, FETCH_LAT = 3, LEN_W = 6;
  localparam int ROW_W = $clog2(ROWS), ADDR_W = $clog2(ROWS) + $clog2(BANKS);
  localparam int WORDS = ROWS * BANKS;

  logic clk = 1'b0, rstN = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [LEN_W-1:0] reqLen = '0;
  logic reqValid = 1'b0, reqReady, outValid, outLast, wrValid = 1'b0, wrReady;
  logic [WORD_W-1:0] outData;
  logic [ROW_W-1:0] wrRow = '0;
  logic [BANKS*WORD_W-1:0] wrData = '0;

  logic [WORD_W-1:0] mdl [WORDS];
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  row_buffered_mem #(.BANKS(BANKS), .ROWS(ROWS), .WORD_W(WORD_W),
                     .FETCH_LAT(FETCH_LAT), .LEN_W(LEN_W)) u0 (
    .clk(clk), .rstN(rstN), .reqAddr(reqAddr), .reqLen(reqLen),
    .reqValid(reqValid), .reqReady(reqReady), .outData(outData),
    .outValid(outValid), .outLast(outLast), .wrValid(wrValid),
    .wrRow(wrRow), .wrData(wrData), .wrReady(wrReady));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // R2: write one whole row and mirror it in the model
  task automatic writeRow(input int row, input int seed);
    @(negedge clk);
    wrValid = 1'b1;
    wrRow   = ROW_W'(row);
    for (int b = 0; b < BANKS; b++) begin
      wrData[b*WORD_W +: WORD_W] = WORD_W'(seed + row * 37 + b * 11);
      mdl[row*BANKS + b]         = WORD_W'(seed + row * 37 + b * 11);
    end
    check(wrReady == 1'b1, "R2 wrReady", int'(wrReady), 1);
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  // R3 R4 R5 R6 R8 R9: one read, every word compared with the model
  task automatic doRead(input int addr, input int len, input bit gapless, input bit poke);
    int n = 0, prevIdx = 0;
    @(negedge clk);
    reqAddr = ADDR_W'(addr); reqLen = LEN_W'(len); reqValid = 1'b1;
    check(reqReady == 1'b1, "R6 ready before read", int'(reqReady), 1);
    @(negedge clk);
    reqValid = 1'b0;
    for (int idx = 0; idx < 200 && n < len; idx++) begin
      if (idx > 0) @(negedge clk);
      if (poke && idx == 1) begin
        wrValid = 1'b1; wrRow = ROW_W'(addr / BANKS); wrData = '1;
      end
      if (poke && idx == 2)
        check(wrReady == 1'b0 && reqReady == 1'b0, "R8 ready low while busy",
              int'(wrReady) + int'(reqReady), 0);
      if (poke && idx == 3) wrValid = 1'b0;
      if (outValid) begin
        check(outData == mdl[(addr + n) % WORDS], "R3 R4 word",
              int'(outData), int'(mdl[(addr + n) % WORDS]));
        check(outLast == (n == len - 1), "R6 last flag", int'(outLast), int'(n == len - 1));
        if (n == 0) check(idx == FETCH_LAT, "R5 first word latency", idx, FETCH_LAT);
        if (gapless && n > 0) check(idx == prevIdx + 1, "R9 gapless stream", idx, prevIdx + 1);
        prevIdx = idx;
        n++;
      end
    end
    wrValid = 1'b0;
    check(n == len, "R3 word count", n, len);
    @(negedge clk);
    check(reqReady == 1'b1 && outValid == 1'b0, "R6 idle after last",
          int'(reqReady), 1);
  endtask

  // R7: zero-length request
  task automatic zeroLen();
    int seen = 0;
    @(negedge clk);
    reqAddr = ADDR_W'(6); reqLen = '0; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    for (int i = 0; i < 12; i++) begin
      if (outValid || !reqReady) seen++;
      @(negedge clk);
    end
    check(seen == 0, "R7 zero length silent", seen, 0);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(reqReady && wrReady && !outValid && !outLast, "R1 reset state",
          {reqReady, wrReady, outValid, outLast}, 4'b1100);
    rstN = 1'b1;
    for (int r = 0; r < ROWS; r++) writeRow(r, 3);
    doRead(8, 4, 1'b1, 1'b0);          // R2 one aligned row
    doRead(4, 12, 1'b1, 1'b0);         // R9 three aligned rows
    doRead(5, 6, 1'b0, 1'b0);          // R4 unaligned, crosses a row
    doRead(7, 1, 1'b0, 1'b0);          // R4 R6 single word in last bank
    doRead(29, 8, 1'b0, 1'b0);         // R3 wraps past the top
    zeroLen();                         // R7
    doRead(16, 6, 1'b0, 1'b1);         // R8 write offered mid-read
    doRead(16, 4, 1'b1, 1'b0);         // R8 row 4 unchanged
    writeRow(7, 90);                   // R2 overwrite
    doRead(0, 32, 1'b1, 1'b0);         // R3 R9 full sweep
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule